// File: doc/BRIEF.md
# Half-Band Decimate-by-Two Filter

This block is the half-band stage that sits behind a CIC integrator-comb section in a multistage decimation chain. It accepts a signed 16-bit sample stream qualified by a valid strobe, low-pass filters it with a 15-tap linear-phase half-band response, and emits one filtered sample for every second accepted input. The output sample rate is therefore half the accepted input rate.

The half-band shape is what keeps the block small. Every tap at an even, non-zero distance from the centre is zero. The centre tap is exactly one half, and the response is mirror-symmetric. Mirrored samples are summed before any product is formed. This leaves four distinct 8-bit side coefficients, each applied through a canonic-signed-digit shift-and-add network. The centre tap costs only a fixed shift. The wide internal sum is rounded and clipped to a 16-bit result. Only the outputs that survive decimation are computed.

Side coefficients at scale 128, from the outermost tap inward: -1, 5, -12, 40. The centre tap is 64.

Top module: `hb_decim2`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_data is 0, the delay line holds zeros and the decimation phase is cleared.
- R2: out_valid is a single-cycle pulse. Exactly one pulse is produced for every two accepted inputs, and never two in consecutive cycles.
- R3: A cycle with in_valid low is ignored: in_data is not stored, the phase does not advance, and out_data does not change.
- R4: For a window of the 15 most recent accepted samples x[0] (newest) to x[14], the filter sum is -1·(x0+x14) + 5·(x2+x12) - 12·(x4+x10) + 40·(x6+x8) + 64·x7. Taps 1, 3, 5, 9, 11 and 13 contribute nothing.
- R5: The result is the filter sum divided by 128 and rounded half toward positive infinity, i.e. floor((sum+64)/128).
- R6: A rounded result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R7: An input accepted in the same cycle that an output is being produced is stored normally, and the output reflects only the window before that input.
- R8: After reset, the first output belongs to the second accepted input. The output appears with out_valid high in the second cycle after the clock edge that accepted that input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | High when in_data holds a sample to accept |
| in_data | input | 16 | Signed two's complement input sample |
| out_valid | output | 1 | One-cycle pulse marking a new output sample |
| out_data | output | 16 | Signed rounded and saturated filter output |

## Verification
Two events can fall in the same cycle. The output register loads the sum of the window captured at the previous edge, and a fresh sample shifts into the delay line at that same edge. The bench provokes this by holding in_valid high for long random runs, so that every output load meets a new acceptance. It also interleaves idle gaps in which in_data carries junk. Every output is judged against a bench-side model of the last 15 accepted samples. The model checks both the value and the exact cycle of arrival, so a window shifted by one sample, or an output that is early or late, is reported.

// File: rtl/hb_decim2_pkg.sv
package hb_decim2_pkg;
  localparam int NTAP  = 15;
  localparam int NSIDE = (NTAP - 1 + 3) / 4;
  localparam int CW    = 8;
  localparam int FRAC  = CW - 1;

  // Side coefficient k applies to taps 2k and NTAP-1-2k, scale 2^FRAC.
  function automatic int side_coef(input int k);
    case (k)
      0:       return -1;
      1:       return 5;
      2:       return -12;
      default: return 40;
    endcase
  endfunction

  // Signed-digit split: positive-weight digits of |c| (swapped for c<0).
  function automatic logic [CW:0] csd_plus(input int c);
    int m;
    int t;
    int p;
    int n;
    m = (c < 0) ? -c : c;
    t = 3 * m;
    p = ((m ^ t) & t) >> 1;
    n = ((m ^ t) & m) >> 1;
    return (c < 0) ? n[CW:0] : p[CW:0];
  endfunction

  function automatic logic [CW:0] csd_minus(input int c);
    int m;
    int t;
    int p;
    int n;
    m = (c < 0) ? -c : c;
    t = 3 * m;
    p = ((m ^ t) & t) >> 1;
    n = ((m ^ t) & m) >> 1;
    return (c < 0) ? p[CW:0] : n[CW:0];
  endfunction
endpackage

// File: rtl/hb_tapline.sv
module hb_tapline #(
  parameter int DW   = 16,
  parameter int NTAP = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [DW-1:0]             in_data,
  output logic [NTAP-1:0][DW-1:0]   taps,
  output logic                      calc
);
  logic [NTAP-1:0][DW-1:0] taps_q, taps_d;
  logic                    phase_q, phase_d;
  logic                    calc_q, calc_d;

  always_comb begin
    taps_d  = taps_q;
    phase_d = phase_q;
    calc_d  = 1'b0;
    if (in_valid) begin
      taps_d[0] = in_data;
      for (int i = 1; i < NTAP; i++) taps_d[i] = taps_q[i-1];
      phase_d = ~phase_q;
      calc_d  = phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps_q  <= '0;
      phase_q <= 1'b0;
      calc_q  <= 1'b0;
    end else begin
      if (in_valid) begin
        taps_q  <= taps_d;
        phase_q <= phase_d;
      end
      calc_q <= calc_d;
    end
  end

  assign taps = taps_q;
  assign calc = calc_q;
endmodule

// File: rtl/hb_csd_mult.sv
module hb_csd_mult #(
  parameter int IW   = 17,
  parameter int CW   = 8,
  parameter int COEF = 5
) (
  input  logic signed [IW-1:0]    x,
  output logic signed [IW+CW:0]   p
);
  localparam int PW = IW + CW + 1;
  localparam logic [CW:0] POS = hb_decim2_pkg::csd_plus(COEF);
  localparam logic [CW:0] NEG = hb_decim2_pkg::csd_minus(COEF);

  logic signed [PW-1:0] xe;
  logic signed [PW-1:0] term [CW+1];

  assign xe = PW'(x);

  for (genvar j = 0; j <= CW; j++) begin : g_digit
    if (POS[j]) begin : g_pos
      assign term[j] = xe <<< j;
    end else if (NEG[j]) begin : g_neg
      assign term[j] = -(xe <<< j);
    end else begin : g_zero
      assign term[j] = '0;
    end
  end

  always_comb begin
    p = '0;
    for (int j = 0; j <= CW; j++) p = p + term[j];
  end
endmodule

// File: rtl/hb_round_sat.sv
module hb_round_sat #(
  parameter int AW   = 28,
  parameter int FRAC = 7,
  parameter int OW   = 16
) (
  input  logic signed [AW-1:0] acc,
  output logic signed [OW-1:0] y
);
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] OMAX = AW'((64'sd1 <<< (OW - 1)) - 1);
  localparam logic signed [AW-1:0] OMIN = -(AW'(64'sd1 <<< (OW - 1)));

  logic signed [AW-1:0] rnd;
  logic signed [AW-1:0] q;

  always_comb begin
    rnd = acc + HALF;
    q   = rnd >>> FRAC;
    if (q > OMAX)      y = OMAX[OW-1:0];
    else if (q < OMIN) y = OMIN[OW-1:0];
    else               y = q[OW-1:0];
  end
endmodule

// File: rtl/hb_decim2.sv
module hb_decim2 #(
  parameter int DW = 16,
  parameter int OW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  import hb_decim2_pkg::*;

  localparam int IW  = DW + 1;
  localparam int PW  = IW + CW + 1;
  localparam int AW  = PW + 2;
  localparam int MID = (NTAP - 1) / 2;

  logic [NTAP-1:0][DW-1:0] taps;
  logic                    calc;
  logic signed [PW-1:0]    prod [NSIDE];
  logic signed [AW-1:0]    acc;
  logic signed [OW-1:0]    y;
  logic                    out_valid_q;
  logic signed [OW-1:0]    out_data_q;

  hb_tapline #(.DW(DW), .NTAP(NTAP)) i_tapline (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .taps     (taps),
    .calc     (calc)
  );

  for (genvar k = 0; k < NSIDE; k++) begin : g_side
    logic signed [IW-1:0] pre;
    assign pre = IW'(signed'(taps[2*k])) + IW'(signed'(taps[NTAP-1-2*k]));
    hb_csd_mult #(.IW(IW), .CW(CW), .COEF(side_coef(k))) i_mult (
      .x (pre),
      .p (prod[k])
    );
  end

  always_comb begin
    acc = AW'(signed'(taps[MID])) <<< (FRAC - 1);
    for (int k = 0; k < NSIDE; k++) acc = acc + AW'(prod[k]);
  end

  hb_round_sat #(.AW(AW), .FRAC(FRAC), .OW(OW)) i_round (
    .acc (acc),
    .y   (y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= calc;
      if (calc) out_data_q <= y;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
endmodule

// File: rtl/hb_decim2_chk.sv
module hb_decim2_chk #(
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [OW-1:0] out_data
);
  logic ck_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ck_par <= 1'b0;
    else if (in_valid) ck_par <= ~ck_par;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!out_valid && out_data == '0);
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_held_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> out_valid);

  assert_second_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && ck_par, 2));
endmodule

bind hb_decim2 hb_decim2_chk #(.OW(OW)) i_hb_decim2_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_hb_decim2.sv
module test_hb_decim2;
  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic signed [15:0] in_data;
  logic               out_valid;
  logic signed [15:0] out_data;

  hb_decim2 i_hb_decim2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int hist [15];
  bit par = 0;
  int exp_val [$];
  int exp_due [$];
  int pushed = 0;
  int seen = 0;
  string cur_req = "R4";
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int model_out();
    longint s;
    longint q;
    s = -1 * longint'(hist[0] + hist[14]) + 5 * longint'(hist[2] + hist[12])
        - 12 * longint'(hist[4] + hist[10]) + 40 * longint'(hist[6] + hist[8])
        + 64 * longint'(hist[7]);
    q = (s + 64) >>> 7;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  // monitor: value and arrival cycle of each output
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_due.size() > 0 && exp_due[0] < cyc) begin
        chk({cur_req, " missing output (R2)"}, 0, 1);
        void'(exp_due.pop_front());
        void'(exp_val.pop_front());
      end
      if (out_valid) begin
        seen++;
        if (exp_due.size() == 0) begin
          chk({cur_req, " unexpected output (R2/R8)"}, 1, 0);
        end else begin
          chk({cur_req, " output cycle (R8)"}, cyc, exp_due[0]);
          chk({cur_req, " output value"}, int'(out_data), exp_val[0]);
          void'(exp_due.pop_front());
          void'(exp_val.pop_front());
        end
      end
    end
  end

  task automatic send(input bit v, input int x);
    @(negedge clk);
    in_valid = v;
    in_data  = x[15:0];
    @(posedge clk);
    #1;
    if (v) begin
      for (int i = 14; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = int'(signed'(x[15:0]));
      if (par) begin
        exp_val.push_back(model_out());
        exp_due.push_back(cyc + 1);
        pushed++;
      end
      par = ~par;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(1'b0, int'($urandom));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    for (int i = 0; i < 15; i++) hist[i] = 0;
    par = 0;
    exp_val.delete();
    exp_due.delete();
    pushed = 0;
    seen = 0;
    @(negedge clk);
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R1 reset out_data", int'(out_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_scn();
    idle(4);
    chk({cur_req, " output count (R2)"}, seen, pushed);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    for (int i = 0; i < 15; i++) hist[i] = 0;

    // R1 + R4: impulse in both decimation phases
    cur_req = "R4";
    do_reset();
    send(1, 1024);
    for (int i = 0; i < 20; i++) send(1, 0);
    finish_scn();
    do_reset();
    send(1, 0);
    send(1, -2048);
    for (int i = 0; i < 20; i++) send(1, 0);
    finish_scn();

    // R8: a single accepted input yields nothing
    cur_req = "R8";
    do_reset();
    send(1, 12345);
    idle(6);
    chk("R8 no output after one input", seen, 0);
    send(1, 999);
    finish_scn();

    // R5: half-way rounding with small impulses
    cur_req = "R5";
    foreach (hist[i]) ;
    for (int a = -3; a <= 3; a++) begin
      do_reset();
      send(1, a);
      for (int i = 0; i < 16; i++) send(1, 0);
      finish_scn();
      do_reset();
      send(1, 0);
      send(1, a);
      for (int i = 0; i < 16; i++) send(1, 0);
      finish_scn();
    end

    // R6: saturation at both rails
    cur_req = "R6";
    for (int s = 0; s < 2; s++) begin
      do_reset();
      send(1, 0);
      for (int t = 0; t < 15; t++) begin
        int idx;
        int sg;
        idx = 14 - t;
        case (idx)
          0, 4, 10, 14:    sg = -1;
          2, 6, 7, 8, 12:  sg = 1;
          default:         sg = 0;
        endcase
        if (s == 1) sg = -sg;
        send(1, (sg > 0) ? 32767 : (sg < 0) ? -32768 : 0);
      end
      finish_scn();
      chk("R6 rail value", int'(out_data), (s == 0) ? 32767 : -32768);
    end

    // R3: idle gaps with junk data
    cur_req = "R3";
    do_reset();
    for (int i = 0; i < 400; i++) begin
      send(1, int'($urandom_range(0, 65535)) - 32768);
      if ($urandom_range(0, 2) == 0) idle(int'($urandom_range(1, 3)));
    end
    finish_scn();

    // R7: continuous acceptance overlapping every output
    cur_req = "R7";
    do_reset();
    for (int i = 0; i < 2000; i++) send(1, int'($urandom_range(0, 65535)) - 32768);
    finish_scn();
    do_reset();
    for (int i = 0; i < 600; i++) send(1, ($urandom_range(0, 1) == 1) ? 32767 : -32768);
    finish_scn();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule